// File: doc/BRIEF.md
# Adjustable-Rate Nanosecond Time Counter

This block keeps a free-running nanosecond time-of-day count for packet timestamping. On every reference clock cycle in which it is enabled, it adds a programmable nanosecond step to a 32-bit accumulator. To trim the rate, a correction timer replaces that step with a second programmable step once every N cycles. A correction step larger than the normal step makes the clock run fast. A smaller one makes it run slow.

The count can be folded back at a programmable period, which is 2^31 out of reset. Whenever it rolls over, the block raises a one-cycle wrap pulse. A second output gives the same pulse gated by a compare-enable bit, for downstream compare logic. Software uses a small word-addressed register port to do four things: control counting, load the counter, restart it, and capture the live count into a readable register.

Top module: `nsTimeCounter`

## Requirements
- R1: After reset: the control, correction-period and step registers read 0; the captured time reads 0; the period register reads 0x8000_0000; both pulse outputs are low.
- R2: Register map by word address: 0 control, 1 time (a write loads the counter, a read returns the last capture), 2 wrap period, 3 correction period, 4 steps. Any other address reads 0.
- R3: When control bit 0 is 1, each clock edge adds a step to the counter. When it is 0, the counter holds its value.
- R4: The step register holds the normal step in bits 6:0. Each step that is not a correction step adds this amount.
- R5: The correction-period register holds V = N-1. When V is nonzero, the step register's bits 14:8 replace the normal step on every (V+1)-th enabled cycle, which is the last cycle of each group. The phase advances only on enabled cycles.
- R6: When V is 0, correction is off and only the normal step is used.
- R7: When control bits 5:4 are nonzero and count+step reaches the period, the counter becomes count+step-period. Otherwise it wraps modulo 2^32.
- R8: The wrap output is high for exactly the cycle after each edge at which the counter rolls over. The compare output is the same pulse, but only while control bit 7 is 1.
- R9: Writing control bit 9 clears the counter and the correction phase at that edge. The bit is not stored and reads 0.
- R10: Writing control bit 11 sets a pending flag, which reads back at bit 11. At the next edge the running count is copied into the time register and the flag clears.
- R11: A write to the time register sets the counter to the written value at that edge. The load takes the place of that cycle's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| wrapPulse | output | 1 | One-cycle rollover pulse |
| cmpEvent | output | 1 | Rollover pulse gated by compare enable |

## Verification
A wrong correction phase or step selection shows up in the next captured time. That value is off by an exact multiple of the difference between the two steps, and the error can be read two cycles after the capture request. A counter that folds at the wrong threshold shows up sooner: the wrap and compare pulses appear in the wrong cycle, and they are compared against an independent model on every clock. A stuck pending flag or a wrong load shows in the control or time read within one to two cycles.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TIME = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CPER = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STEP = 3'd4;

  localparam int BIT_EN      = 0;
  localparam int BIT_MODE_LO = 4;
  localparam int BIT_CMP     = 7;
  localparam int BIT_RESTART = 9;
  localparam int BIT_CAP     = 11;
  localparam int STEP_CORR_LSB = 8;

  typedef struct packed {
    logic tick;
    logic restart;
    logic load;
    logic capture;
    logic periodic;
  } ntcStrobes_t;
endpackage

// File: rtl/ntcControl.sv
module ntcControl
  import ntc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7,
  parameter int CPER_W = 31,
  parameter logic [CNT_W-1:0] RST_PERIOD = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  capVal,
  output logic [DATA_W-1:0] rdData,
  output ntcStrobes_t       strobes,
  output logic [CNT_W-1:0]  loadVal,
  output logic [INC_W-1:0]  incNorm,
  output logic [INC_W-1:0]  incCorr,
  output logic [CNT_W-1:0]  period,
  output logic [CPER_W-1:0] corrPer,
  output logic              cmpEnable
);
  logic       enReg, cmpEnReg, capPend;
  logic [1:0] modeReg;
  logic       wrCtrl;

  assign wrCtrl = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg    <= 1'b0;
      modeReg  <= '0;
      cmpEnReg <= 1'b0;
      capPend  <= 1'b0;
      incNorm  <= '0;
      incCorr  <= '0;
      period   <= RST_PERIOD;
      corrPer  <= '0;
    end else begin
      capPend <= wrCtrl && wrData[BIT_CAP];
      if (wrCtrl) begin
        enReg    <= wrData[BIT_EN];
        modeReg  <= wrData[BIT_MODE_LO +: 2];
        cmpEnReg <= wrData[BIT_CMP];
      end
      if (wrEn && addr == ADDR_PER)  period  <= wrData[CNT_W-1:0];
      if (wrEn && addr == ADDR_CPER) corrPer <= wrData[CPER_W-1:0];
      if (wrEn && addr == ADDR_STEP) begin
        incNorm <= wrData[INC_W-1:0];
        incCorr <= wrData[STEP_CORR_LSB +: INC_W];
      end
    end
  end

  always_comb begin
    strobes.tick     = enReg;
    strobes.restart  = wrCtrl && wrData[BIT_RESTART];
    strobes.load     = wrEn && (addr == ADDR_TIME);
    strobes.capture  = capPend;
    strobes.periodic = |modeReg;
  end

  assign loadVal   = wrData[CNT_W-1:0];
  assign cmpEnable = cmpEnReg;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: begin
        rdData[BIT_EN]           = enReg;
        rdData[BIT_MODE_LO +: 2] = modeReg;
        rdData[BIT_CMP]          = cmpEnReg;
        rdData[BIT_CAP]          = capPend;
      end
      ADDR_TIME: rdData[CNT_W-1:0]  = capVal;
      ADDR_PER:  rdData[CNT_W-1:0]  = period;
      ADDR_CPER: rdData[CPER_W-1:0] = corrPer;
      ADDR_STEP: begin
        rdData[INC_W-1:0]              = incNorm;
        rdData[STEP_CORR_LSB +: INC_W] = incCorr;
      end
      default: rdData = '0;
    endcase
  end

  // R3: the enable seen by the datapath changes only through a control write
  p_tick_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !wrCtrl |=> $stable(strobes.tick));

  // R9: the restart request never persists into the following cycle on its own
  p_restart_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> !strobes.restart);
endmodule

// File: rtl/ntcCorrTimer.sv
module ntcCorrTimer #(
  parameter int CPER_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              clear,
  input  logic [CPER_W-1:0] corrPer,
  output logic              useCorr
);
  logic [CPER_W-1:0] phase;
  logic              corrOff;

  assign corrOff = (corrPer == '0);
  assign useCorr = !corrOff && (phase == corrPer);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= '0;
    end else if (advance) begin
      if (corrOff || useCorr) phase <= '0;
      else                    phase <= phase + 1'b1;
    end
  end

  // R6: with correction off the phase never leaves zero
  p_corr_off_r6: assert property (@(posedge clk) disable iff (rst)
    corrOff && !clear |=> phase == '0 || !$stable(corrPer));

  // R9: restart resets the correction phase
  p_phase_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> phase == '0);
endmodule

// File: rtl/ntcDatapath.sv
module ntcDatapath
  import ntc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7,
  parameter int CPER_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  ntcStrobes_t       strobes,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic [INC_W-1:0]  incNorm,
  input  logic [INC_W-1:0]  incCorr,
  input  logic [CNT_W-1:0]  period,
  input  logic [CPER_W-1:0] corrPer,
  input  logic              cmpEnable,
  output logic [CNT_W-1:0]  capVal,
  output logic              wrapPulse,
  output logic              cmpEvent
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] count;
  logic [INC_W-1:0] step;
  logic [SUM_W-1:0] sum, excess;
  logic             useCorr, reachPer, rolled;
  logic [CNT_W-1:0] nextTick;

  ntcCorrTimer #(.CPER_W(CPER_W)) uCorr (
    .clk     (clk),
    .rst     (rst),
    .advance (strobes.tick),
    .clear   (strobes.restart),
    .corrPer (corrPer),
    .useCorr (useCorr)
  );

  always_comb begin
    step     = useCorr ? incCorr : incNorm;
    sum      = {1'b0, count} + SUM_W'(step);
    excess   = sum - {1'b0, period};
    reachPer = strobes.periodic && (sum >= {1'b0, period});
    rolled   = reachPer || sum[CNT_W];
    nextTick = reachPer ? excess[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      capVal    <= '0;
      wrapPulse <= 1'b0;
      cmpEvent  <= 1'b0;
    end else begin
      if (strobes.capture) capVal <= count;
      if (strobes.restart) begin
        count     <= '0;
        wrapPulse <= 1'b0;
        cmpEvent  <= 1'b0;
      end else if (strobes.load) begin
        count     <= loadVal;
        wrapPulse <= 1'b0;
        cmpEvent  <= 1'b0;
      end else if (strobes.tick) begin
        count     <= nextTick;
        wrapPulse <= rolled;
        cmpEvent  <= rolled && cmpEnable;
      end else begin
        wrapPulse <= 1'b0;
        cmpEvent  <= 1'b0;
      end
    end
  end

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    strobes.restart |=> count == '0 && !wrapPulse);

  p_load_value_r11: assert property (@(posedge clk) disable iff (rst)
    strobes.load && !strobes.restart |=> count == $past(loadVal));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !strobes.tick && !strobes.load && !strobes.restart |=> $stable(count));

  p_capture_copy_r10: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> capVal == $past(count));

  p_cmp_gated_r8: assert property (@(posedge clk) disable iff (rst)
    cmpEvent |-> wrapPulse);

  p_wrap_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |-> $past(strobes.tick && !strobes.load && !strobes.restart));
endmodule

// File: rtl/nsTimeCounter.sv
module nsTimeCounter
  import ntc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7,
  parameter int CPER_W = 31,
  parameter logic [CNT_W-1:0] RST_PERIOD = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              wrapPulse,
  output logic              cmpEvent
);
  ntcStrobes_t       strobes;
  logic [CNT_W-1:0]  loadVal, period, capVal;
  logic [INC_W-1:0]  incNorm, incCorr;
  logic [CPER_W-1:0] corrPer;
  logic              cmpEnable;

  ntcControl #(
    .CNT_W(CNT_W), .INC_W(INC_W), .CPER_W(CPER_W), .RST_PERIOD(RST_PERIOD)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .capVal(capVal), .rdData(regRdData), .strobes(strobes), .loadVal(loadVal),
    .incNorm(incNorm), .incCorr(incCorr), .period(period), .corrPer(corrPer),
    .cmpEnable(cmpEnable)
  );

  ntcDatapath #(
    .CNT_W(CNT_W), .INC_W(INC_W), .CPER_W(CPER_W)
  ) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .loadVal(loadVal),
    .incNorm(incNorm), .incCorr(incCorr), .period(period), .corrPer(corrPer),
    .cmpEnable(cmpEnable), .capVal(capVal), .wrapPulse(wrapPulse),
    .cmpEvent(cmpEvent)
  );
endmodule

// File: tb/sim_nsTimeCounter.sv
module sim_nsTimeCounter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        wrapPulse, cmpEvent;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nsTimeCounter u0 (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .wrapPulse(wrapPulse), .cmpEvent(cmpEvent)
  );

  // Reference model written from the requirements
  logic        mEn, mCmpEn, mPend, mWrap, mCmp, mUse, mReach;
  logic [1:0]  mMode;
  logic [6:0]  mInc, mCorr, mStep;
  logic [31:0] mPer, mCnt, mCap;
  logic [30:0] mCper, mPhase;
  logic [32:0] mSum;
  logic        wCtrl;

  always @(posedge clk) begin
    if (rst) begin
      mEn = 0; mCmpEn = 0; mPend = 0; mWrap = 0; mCmp = 0; mMode = 0;
      mInc = 0; mCorr = 0; mPer = 32'h8000_0000; mCnt = 0; mCap = 0;
      mCper = 0; mPhase = 0;
    end else begin
      wCtrl  = regWrEn && regAddr == 3'd0;
      mUse   = (mCper != 0) && (mPhase == mCper);
      mStep  = mUse ? mCorr : mInc;
      mSum   = {1'b0, mCnt} + {26'd0, mStep};
      mReach = (mMode != 0) && (mSum >= {1'b0, mPer});
      if (mPend) mCap = mCnt;
      if (wCtrl && regWrData[9]) begin
        mCnt = 0; mWrap = 0; mCmp = 0; mPhase = 0;
      end else begin
        if (regWrEn && regAddr == 3'd1) begin
          mCnt = regWrData; mWrap = 0; mCmp = 0;
        end else if (mEn) begin
          mWrap = mReach || mSum[32];
          mCmp  = mWrap && mCmpEn;
          mCnt  = mReach ? 32'(mSum - {1'b0, mPer}) : mSum[31:0];
        end else begin
          mWrap = 0; mCmp = 0;
        end
        if (mEn) mPhase = (mCper == 0 || mUse) ? 31'd0 : mPhase + 31'd1;
      end
      mPend = wCtrl && regWrData[11];
      if (wCtrl) begin
        mEn = regWrData[0]; mMode = regWrData[5:4]; mCmpEn = regWrData[7];
      end
      if (regWrEn && regAddr == 3'd2) mPer = regWrData;
      if (regWrEn && regAddr == 3'd3) mCper = regWrData[30:0];
      if (regWrEn && regAddr == 3'd4) begin
        mInc = regWrData[6:0]; mCorr = regWrData[14:8];
      end
    end
  end

  function automatic logic [31:0] ctrlView();
    return (32'(mPend) << 11) | (32'(mCmpEn) << 7) | (32'(mMode) << 4) | 32'(mEn);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R8: pulse outputs compared every cycle
  always @(negedge clk) begin
    if (!rst && !done) check("R8 pulses", {30'd0, wrapPulse, cmpEvent}, {30'd0, mWrap, mCmp});
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic capNow(input string tag, input logic [31:0] ctrlBase);
    logic [31:0] v;
    wr(3'd0, ctrlBase | 32'h800);
    rd(3'd0, v);
    check("R10 pending set", {31'd0, v[11]}, 32'd1);
    check("R10 ctrl view", v, ctrlView());
    @(posedge clk);
    rd(3'd1, v);
    check(tag, v, mCap);
    rd(3'd0, v);
    check("R10 pending clear", {31'd0, v[11]}, 32'd0);
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 32'd0);
    rd(3'd1, v); check("R1 time", v, 32'd0);
    rd(3'd2, v); check("R1 period", v, 32'h8000_0000);
    rd(3'd3, v); check("R1 corr period", v, 32'd0);
    rd(3'd4, v); check("R1 steps", v, 32'd0);
    rd(3'd6, v); check("R2 unmapped", v, 32'd0);
    check("R1 pulses", {30'd0, wrapPulse, cmpEvent}, 32'd0);
  endtask

  task automatic tLoadHold();
    logic [31:0] v;
    wr(3'd4, 32'h0000_0C08);
    rd(3'd4, v); check("R2 step readback", v, 32'h0000_0C08);
    wr(3'd1, 32'd1234);
    idle(4);
    capNow("R11 load held", 32'd0);
    rd(3'd1, v); check("R3 disabled hold", v, 32'd1234);
  endtask

  task automatic tNormal();
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd8);
    wr(3'd1, 32'd100);
    wr(3'd0, 32'd1);
    idle(10);
    capNow("R4 normal step", 32'd1);
    idle(3);
    capNow("R4 normal step again", 32'd1);
  endtask

  task automatic tCorr(input string tag, input logic [31:0] steps, input logic [31:0] v);
    wr(3'd0, 32'd0);
    wr(3'd4, steps);
    wr(3'd3, v);
    wr(3'd0, 32'h201);
    idle(17);
    capNow(tag, 32'd1);
    idle(6);
    capNow(tag, 32'd1);
  endtask

  task automatic tPeriod(input logic [31:0] ctrlBase);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd8);
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h200);
    wr(3'd0, ctrlBase);
    idle(40);
    capNow("R7 periodic fold", ctrlBase);
  endtask

  task automatic tFreeWrap();
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd8);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd0, 32'h81);
    idle(5);
    capNow("R7 modulo wrap", 32'h81);
  endtask

  task automatic tRestart();
    logic [31:0] v;
    wr(3'd4, 32'd8);
    wr(3'd1, 32'd5000);
    wr(3'd0, 32'h201);
    rd(3'd0, v); check("R9 restart not stored", {31'd0, v[9]}, 32'd0);
    idle(2);
    capNow("R9 restart cleared", 32'd1);
  endtask

  initial begin
    idle(3);
    #1 rst = 1'b0;
    tReset();
    tLoadHold();
    tNormal();
    tCorr("R5 correction faster", 32'h0000_0C08, 32'd3);
    tCorr("R5 correction slower", 32'h0000_0508, 32'd1);
    tCorr("R6 correction off", 32'h0000_3208, 32'd0);
    tPeriod(32'h91);
    tPeriod(32'h21);
    tFreeWrap();
    tRestart();
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog all-requirements act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule